// File: doc/BRIEF.md
# Transmit Control and Status Register

This block holds the per-packet transmit setup and the end-of-packet result flags for a network transmitter. When the transmit engine starts a packet, the block takes four mode bits from that packet's configuration word. When the packet ends, it captures the result flags. Some flags are cleared once the status has been written back to memory. Others are cleared, or one is set, when the next packet starts.

The block drives three things derived from the mode bits. One is a level that tells the engine to omit the frame check sequence. Another is a one-cycle pulse marking the start of the late-collision window, taken from either the preamble or the frame delimiter event. The third is a one-shot interrupt, which fires only when the loaded interrupt-request bit changes from 0 to 1.

An internal deferral timer counts consecutive cycles of deferral. When the count reaches its limit, the timer flags excessive deferral and pulses an abort to the engine. A host reads the whole 16-bit word on a plain read port.

Top module: `txctl_stat_reg`

## Requirements
- R1: Hardware reset (rst_n low) makes the read word 16'h0101: bit 8 (no carrier) and bit 0 (sent OK) are 1, and every other bit, including bit 1, is 0.
- R2: A tx_start_i pulse loads cfg_i[15:12] into word bits 15:12. Bit 15 is interrupt request, bit 14 is window-start select, bit 13 is FCS omit and bit 12 is timer disable. crc_omit_o always equals word bit 13.
- R3: A tx_end_i pulse loads result_i[9:0] into word bits 9:0, with bit 4 excepted. Word bit 9 is deferred, 8 no carrier, 7 carrier lost, 6 too many collisions, 5 late collision, 3 monitored bad, 2 FIFO underrun, 1 byte-count mismatch and 0 sent OK.
- R4: A wb_done_i pulse clears word bits 9 and 5 and leaves every other bit unchanged.
- R5: A tx_start_i pulse clears word bits 10, 7, 6 and 1, sets bit 8, and leaves bits 9, 5, 3, 2 and 0 unchanged.
- R6: irq_o is high for exactly the one cycle after a tx_start_i pulse whose cfg_i[15] is 1 while word bit 15 was 0. It is low at all other times.
- R7: With word bit 12 at 0, DEFER_LIMIT consecutive clock edges with defer_i high set word bit 10 and pulse abort_o for one cycle. A cycle with defer_i low restarts the count.
- R8: While word bit 12 is 1, word bit 10 is never set and abort_o stays low, however long defer_i stays high.
- R9: owc_start_o pulses one cycle after sfd_i when word bit 14 is 0, or one cycle after preamble_i when it is 1.
- R10: soft_rst_i has no effect on the word. Bits 11 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| soft_rst_i | input | 1 | Software reset strobe, ignored by this register |
| tx_start_i | input | 1 | Packet start / descriptor fetched strobe |
| cfg_i | input | 16 | Packet configuration word, bits 15:12 used |
| tx_end_i | input | 1 | Packet finished strobe |
| result_i | input | 10 | Result conditions at packet end |
| wb_done_i | input | 1 | Status written back strobe |
| defer_i | input | 1 | Engine is deferring (level) |
| sfd_i | input | 1 | Frame delimiter sent strobe |
| preamble_i | input | 1 | First preamble bit sent strobe |
| word_o | output | 16 | Register read value |
| crc_omit_o | output | 1 | Send frame without FCS |
| owc_start_o | output | 1 | Late-collision window start pulse |
| irq_o | output | 1 | One-shot interrupt |
| abort_o | output | 1 | Excessive-deferral abort pulse |

## Verification
The assertions assume that tx_start_i, tx_end_i and wb_done_i are never high in the same cycle. They also assume that a start does not coincide with the deferral limit being reached. The random part of the bench meets both assumptions by choosing exactly one strobe per cycle and holding defer_i low. The timer is exercised only in directed runs, and no strobe is driven while those runs are counting.

// File: rtl/txcsr_pkg.sv
// Package: bit positions of the transmit control/status word.
// Assumes a 16-bit word; positions are fixed because software decodes them.
package txcsr_pkg;
    localparam int WORD_W   = 16;
    localparam int MODE_W   = 4;
    localparam int RES_W    = 10;
    localparam int MODE_LSB = 12;
    localparam int B_IRQREQ = 15;
    localparam int B_WINSEL = 14;
    localparam int B_FCSOFF = 13;
    localparam int B_TMROFF = 12;
    localparam int B_SPARE  = 11;
    localparam int B_XDEFER = 10;
    localparam int B_DEFER  = 9;
    localparam int B_NOCAR  = 8;
    localparam int B_CARLOS = 7;
    localparam int B_XCOLL  = 6;
    localparam int B_LATE   = 5;
    localparam int B_RSVD   = 4;
    localparam int B_SENTOK = 0;
    localparam logic [WORD_W-1:0] RESET_WORD = 16'h0101;

    typedef struct packed {
        logic irq_req;
        logic win_sel;
        logic fcs_off;
        logic tmr_off;
    } mode_t;
endpackage

// File: rtl/txcsr_mode.sv
// Mode latch: holds the four per-packet mode bits, detects the 0->1
// interrupt-request edge and selects the late-collision window start.
// Assumes tx_start_i is a single-cycle strobe.
module txcsr_mode
    import txcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start_i,
    input  logic [MODE_W-1:0] cfg_mode_i,
    input  logic              sfd_i,
    input  logic              preamble_i,
    output mode_t             mode_o,
    output logic              irq_o,
    output logic              owc_start_o
);
    mode_t mode_q;
    mode_t mode_d;
    logic  irq_q;
    logic  owc_q;

    // Next mode value: reload on packet start only.
    always_comb begin
        mode_d = mode_q;
        if (tx_start_i) begin
            mode_d = mode_t'(cfg_mode_i);
        end
    end

    // Mode storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    // One-shot interrupt on a rising interrupt-request bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= tx_start_i && mode_d.irq_req && !mode_q.irq_req;
        end
    end

    // Window start pulse from the selected engine event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owc_q <= 1'b0;
        end else begin
            owc_q <= mode_q.win_sel ? preamble_i : sfd_i;
        end
    end

    assign mode_o      = mode_q;
    assign irq_o       = irq_q;
    assign owc_start_o = owc_q;
endmodule

// File: rtl/txcsr_defer.sv
// Deferral timer: counts consecutive deferring cycles while enabled and
// raises a single expiry per deferral episode at DEFER_LIMIT cycles.
// Assumes defer_i is a synchronous level from the transmit engine.
module txcsr_defer #(
    parameter int DEFER_LIMIT = 320000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic defer_i,
    output logic expire_o,
    output logic abort_o
);
    localparam int CNT_W = (DEFER_LIMIT > 1) ? $clog2(DEFER_LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEFER_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             fired_q;
    logic             abort_q;
    logic             run;

    assign run      = defer_i && enable_i;
    assign expire_o = run && !fired_q && (cnt_q == LAST);

    // Count consecutive deferral cycles; restart when deferral stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
        end else if (expire_o) begin
            cnt_q   <= '0;
            fired_q <= 1'b1;
        end else if (!fired_q) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Registered abort pulse, aligned with the flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else begin
            abort_q <= expire_o;
        end
    end

    assign abort_o = abort_q;
endmodule

// File: rtl/txcsr_status.sv
// Status flags: result capture at packet end, selective clears at
// write-back and at the next start, and excessive-deferral set.
// Assumes the three strobes are mutually exclusive.
module txcsr_status
    import txcsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start_i,
    input  logic             tx_end_i,
    input  logic             wb_done_i,
    input  logic             expire_i,
    input  logic [RES_W-1:0] result_i,
    output logic [B_XDEFER:0] flags_o
);
    logic [B_XDEFER:0] flg_q;
    logic [B_XDEFER:0] flg_d;

    // Next flag value by lifecycle event.
    always_comb begin
        flg_d = flg_q;
        if (expire_i) begin
            flg_d[B_XDEFER] = 1'b1;
        end
        if (tx_end_i) begin
            flg_d[RES_W-1:0] = result_i;
        end
        if (wb_done_i) begin
            flg_d[B_DEFER] = 1'b0;
            flg_d[B_LATE]  = 1'b0;
        end
        if (tx_start_i) begin
            flg_d[B_XDEFER] = 1'b0;
            flg_d[B_CARLOS] = 1'b0;
            flg_d[B_XCOLL]  = 1'b0;
            flg_d[1]        = 1'b0;
            flg_d[B_NOCAR]  = 1'b1;
        end
        flg_d[B_RSVD] = 1'b0;
    end

    // Flag storage with hardware reset pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= RESET_WORD[B_XDEFER:0];
        end else begin
            flg_q <= flg_d;
        end
    end

    assign flags_o = flg_q;
endmodule

// File: rtl/txctl_stat_reg.sv
// Top: transmit control/status word. Joins the mode latch, the deferral
// timer and the status flags into one 16-bit read value. The software
// reset input is accepted and deliberately ignored.
module txctl_stat_reg
    import txcsr_pkg::*;
#(
    parameter int DEFER_LIMIT = 320000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst_i,
    input  logic        tx_start_i,
    input  logic [15:0] cfg_i,
    input  logic        tx_end_i,
    input  logic [9:0]  result_i,
    input  logic        wb_done_i,
    input  logic        defer_i,
    input  logic        sfd_i,
    input  logic        preamble_i,
    output logic [15:0] word_o,
    output logic        crc_omit_o,
    output logic        owc_start_o,
    output logic        irq_o,
    output logic        abort_o
);
    mode_t             mode;
    logic              defer_expire;
    logic [B_XDEFER:0] flags;
    logic              unused_soft;

    assign unused_soft = soft_rst_i;

    txcsr_mode u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_start_i  (tx_start_i),
        .cfg_mode_i  (cfg_i[WORD_W-1:MODE_LSB]),
        .sfd_i       (sfd_i),
        .preamble_i  (preamble_i),
        .mode_o      (mode),
        .irq_o       (irq_o),
        .owc_start_o (owc_start_o)
    );

    txcsr_defer #(.DEFER_LIMIT(DEFER_LIMIT)) u_defer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (!mode.tmr_off),
        .defer_i  (defer_i),
        .expire_o (defer_expire),
        .abort_o  (abort_o)
    );

    txcsr_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_start_i (tx_start_i),
        .tx_end_i   (tx_end_i),
        .wb_done_i  (wb_done_i),
        .expire_i   (defer_expire),
        .result_i   (result_i),
        .flags_o    (flags)
    );

    // Assemble the read word.
    always_comb begin
        word_o = {mode, 1'b0, flags};
    end

    assign crc_omit_o = mode.fcs_off;
endmodule

// File: rtl/txcsr_checker.sv
// Checker: temporal properties of the transmit control/status word.
// Assumes mutually exclusive start/end/write-back strobes.
module txcsr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_start_i,
    input logic        tx_end_i,
    input logic        wb_done_i,
    input logic        sfd_i,
    input logic        preamble_i,
    input logic [15:0] cfg_i,
    input logic [15:0] word_o,
    input logic        crc_omit_o,
    input logic        owc_start_o,
    input logic        irq_o,
    input logic        abort_o
);
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !word_o[11] && !word_o[4]); // R10
    AST_LOAD_MODE: assert property (@(posedge clk) disable iff (!rst_n) tx_start_i |=> word_o[15:12] == $past(cfg_i[15:12])); // R2
    AST_FCS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) tx_end_i |=> crc_omit_o == word_o[13]); // R2
    AST_WB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (wb_done_i && !tx_end_i && !tx_start_i) |=> !word_o[9] && !word_o[5]); // R4
    AST_START_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (tx_start_i && !tx_end_i) |=> word_o[8] && !word_o[7] && !word_o[6] && !word_o[1] && !word_o[10]); // R5
    AST_IRQ_EDGE: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> word_o[15] && !$past(word_o[15])); // R6
    AST_IRQ_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n) irq_o |=> !irq_o); // R6
    AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n) abort_o |-> word_o[10] && !word_o[12]); // R7
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) abort_o |=> !abort_o); // R7
    AST_XDEFER_NEEDS_TIMER: assert property (@(posedge clk) disable iff (!rst_n) $rose(word_o[10]) |-> !word_o[12]); // R8
    AST_WINDOW_SEL: assert property (@(posedge clk) disable iff (!rst_n) owc_start_o |-> $past(word_o[14] ? preamble_i : sfd_i)); // R9
endmodule

bind txctl_stat_reg txcsr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_start_i  (tx_start_i),
    .tx_end_i    (tx_end_i),
    .wb_done_i   (wb_done_i),
    .sfd_i       (sfd_i),
    .preamble_i  (preamble_i),
    .cfg_i       (cfg_i),
    .word_o      (word_o),
    .crc_omit_o  (crc_omit_o),
    .owc_start_o (owc_start_o),
    .irq_o       (irq_o),
    .abort_o     (abort_o)
);

// File: tb/sim_txctl_stat_reg.sv
module sim_txctl_stat_reg;
    localparam int LIMIT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst_i = 1'b0;
    logic        tx_start_i = 1'b0;
    logic [15:0] cfg_i = '0;
    logic        tx_end_i = 1'b0;
    logic [9:0]  result_i = '0;
    logic        wb_done_i = 1'b0;
    logic        defer_i = 1'b0;
    logic        sfd_i = 1'b0;
    logic        preamble_i = 1'b0;
    logic [15:0] word_o;
    logic        crc_omit_o, owc_start_o, irq_o, abort_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] model;

    always #5 clk = ~clk;

    txctl_stat_reg #(.DEFER_LIMIT(LIMIT)) u0 (.*);

    function automatic logic [15:0] f_start(logic [15:0] w, logic [15:0] c);
        logic [15:0] n = w;
        n[15:12] = c[15:12];
        n[10] = 0; n[7] = 0; n[6] = 0; n[1] = 0; n[8] = 1;
        return n;
    endfunction

    function automatic logic [15:0] f_end(logic [15:0] w, logic [9:0] r);
        logic [15:0] n = w;
        n[9:0] = r;
        n[4] = 0;
        return n;
    endfunction

    function automatic logic [15:0] f_wb(logic [15:0] w);
        logic [15:0] n = w;
        n[9] = 0; n[5] = 0;
        return n;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: kind 0 idle, 1 start, 2 end, 3 write-back, 4 soft reset.
    task automatic step(int kind, logic [15:0] c, logic [9:0] r, logic s, logic p);
        logic [15:0] nxt;
        logic exp_irq, exp_owc;
        @(negedge clk);
        tx_start_i = (kind == 1); tx_end_i = (kind == 2);
        wb_done_i = (kind == 3); soft_rst_i = (kind == 4);
        cfg_i = c; result_i = r; sfd_i = s; preamble_i = p;
        exp_owc = model[14] ? p : s;
        exp_irq = (kind == 1) && c[15] && !model[15];
        case (kind)
            1: nxt = f_start(model, c);
            2: nxt = f_end(model, r);
            3: nxt = f_wb(model);
            default: nxt = model;
        endcase
        @(posedge clk); #1;
        tx_start_i = 0; tx_end_i = 0; wb_done_i = 0; soft_rst_i = 0;
        sfd_i = 0; preamble_i = 0;
        model = nxt;
        case (kind)
            1: chk("R2/R5 word after start", word_o, model);
            2: chk("R3 word after end", word_o, model);
            3: chk("R4 word after write-back", word_o, model);
            4: chk("R10 word after soft reset", word_o, model);
            default: chk("R10 word idle", word_o, model);
        endcase
        chk("R2 crc_omit_o", crc_omit_o, model[13]);
        chk("R6 irq_o", irq_o, exp_irq);
        chk("R9 owc_start_o", owc_start_o, exp_owc);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset word", word_o, 16'h0101);
        chk("R1 reset irq/abort", {irq_o, abort_o}, 2'b00);
        @(negedge clk); rst_n = 1;
        model = 16'h0101;

        // Directed corners.
        step(4, 16'hFFFF, 10'h3FF, 0, 0);                 // R10 soft reset ignored
        step(2, 16'h0, 10'h3FF, 0, 0);                    // R3, bit 4 stays 0
        step(3, 16'h0, 10'h0, 0, 0);                      // R4
        step(1, 16'h8000, 10'h0, 1, 0);                   // R6 fires, R9 via sfd
        step(1, 16'hC000, 10'h0, 1, 1);                   // R6 no refire
        step(0, 16'h0, 10'h0, 0, 1);                      // R9 via preamble
        step(1, 16'h0000, 10'h0, 0, 0);
        step(1, 16'h8000, 10'h0, 0, 0);                   // R6 fires again after a 0

        // Random mix, deferral held low.
        for (int i = 0; i < 600; i++) begin
            step(int'($urandom_range(0, 4)), 16'($urandom), 10'($urandom),
                 1'($urandom), 1'($urandom));
        end

        // R7: timer enabled, interrupted run then full run.
        step(1, 16'h0000, 10'h0, 0, 0);
        @(negedge clk); defer_i = 1;
        repeat (10) @(posedge clk);
        @(negedge clk); defer_i = 0;
        @(posedge clk);
        @(negedge clk); defer_i = 1;
        repeat (LIMIT - 1) @(posedge clk);
        #1;
        chk("R7 no flag before limit", {word_o[10], abort_o}, 2'b00);
        @(posedge clk); #1;
        chk("R7 flag at limit", {word_o[10], abort_o}, 2'b11);
        @(posedge clk); #1;
        chk("R7 abort one cycle", {word_o[10], abort_o}, 2'b10);
        @(negedge clk); defer_i = 0;
        model[10] = 1;
        step(1, 16'h1000, 10'h0, 0, 0);                   // R5 clears bit 10

        // R8: timer disabled.
        @(negedge clk); defer_i = 1;
        repeat (3 * LIMIT) @(posedge clk);
        #1;
        chk("R8 no flag while disabled", {word_o[10], abort_o}, 2'b00);
        @(negedge clk); defer_i = 0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule